// File: doc/BRIEF.md
# Passive Serial Configuration Host

This block sits on the host side of a programmable device that keeps its configuration in volatile SRAM, and loads a bit-serial image into that device. A start pulse begins a load. The block drives the device's active-low configuration request low for a timed reset interval, then releases it and waits a fixed start-up time. It then takes image bytes from a ready/valid byte source and sends each byte one bit at a time, least significant bit first, on a data line. Each bit is qualified by a rising edge of a configuration clock that the block generates.

The block watches two lines from the device. The first is an open-drain, active-low status line, which reports a configuration fault. The second is a done line, which goes high once the image is complete. Both pass through a chain of synchronizer flops before use. After the done line is seen high, the block gives a fixed number of extra clock cycles so the device can initialize, and then reports done. A status fault or an empty byte source stops the clock and reports an error. A new start pulse given in the error state retries the whole sequence.

All timing comes from the system clock through parameters: system clocks per microsecond, and system clocks per half period of the configuration clock. Elaboration checks refuse settings that would break the device's minimum pulse, wait or clock-phase times.

Top module: `pscfg_host`

## Requirements
- R1: After reset the request line is high, the configuration clock is low, src_ready_o is low, and busy_o, done_o and error_o are all low.
- R2: A start pulse accepted in the idle or error state drives cfg_req_n_o low for exactly RESET_US*CLKS_PER_US system clocks and then drives it high.
- R3: No rising edge of cfg_clk_o occurs until at least START_US*CLKS_PER_US system clocks after cfg_req_n_o returns high.
- R4: Image bytes appear on cfg_data_o least significant bit first, one bit per configuration clock cycle. Data changes only while the clock is low and is held for at least HALF_CYC system clocks before each rising edge. While bits are being shifted, the clock is high for HALF_CYC system clocks and one bit period lasts 2*HALF_CYC+1 system clocks.
- R5: A byte is taken only in a cycle where src_valid_i and src_ready_o are both high. src_ready_o is raised only while the request line is high, the clock is low, and the previous byte has been fully sent. Bytes are taken in source order, and none is taken once the done line has been seen high.
- R6: Once the done line has been seen high at a bit boundary, exactly INIT_CLKS further rising edges of cfg_clk_o are produced. After them done_o goes high, the clock stays low, and no further edges follow.
- R7: If the status line is seen low while bits are being shifted, error_o goes high and the configuration clock stops low.
- R8: If the source has no byte when the next byte is needed and the done line is still low, error_o goes high and the configuration clock stops low.
- R9: A start pulse in the error state restarts the full sequence (request pulse, start-up wait, shifting), and a correct image then completes with done_o high.
- R10: A start pulse while a load is in progress, or once done_o is high, has no effect on the request line or the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle pulse that starts or retries a load |
| src_data_i | input | BYTE_W | Image byte from the byte source |
| src_valid_i | input | 1 | Byte source has a byte available |
| src_ready_o | output | 1 | Block takes the byte in this cycle if valid |
| cfg_req_n_o | output | 1 | Active-low configuration request to the device |
| cfg_clk_o | output | 1 | Configuration clock to the device |
| cfg_data_o | output | 1 | Serial configuration data to the device |
| status_n_i | input | 1 | Open-drain status line from the device, low on fault |
| done_i | input | 1 | Configuration-done line from the device |
| busy_o | output | 1 | A load is in progress |
| done_o | output | 1 | Load and initialization clocks completed |
| error_o | output | 1 | Load stopped on a fault or an empty source |

## Verification
The bench models the target device. It rebuilds bytes from the serial line on each rising clock edge and raises its done line after a set bit count. It compares the rebuilt bytes against a queue of bytes in the order they were offered. Byte patterns with different symmetries (0xA5, 0x3C, 0x81, 0x00, 0xFF, 0x01, 0x80, 0x5A) separate a correct least-significant-first order from a reversed or stuck bit. A full image, a starved image and an image cut short by a status fault each end differently, which separates the done path from both error paths. A second load after an error, and start pulses given during a load and after completion, show whether the retry and ignore rules hold.

// File: rtl/pscfg_pkg.sv
package pscfg_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RESET_PULSE,
      ST_WAIT_START,
      ST_SHIFT,
      ST_INIT_CLOCKS,
      ST_DONE,
      ST_ERROR
   } pscfg_state_e;

endpackage

// File: rtl/pscfg_sync.sv
module pscfg_sync #(
   parameter int         W       = 2,
   parameter int         STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pscfg_sync: STAGES must be at least 2");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= {STAGES{RST_VAL[i]}};
         else        chain_q <= {chain_q[STAGES-2:0], d_i[i]};
      end
      assign q_o[i] = chain_q[STAGES-1];
   end

endmodule

// File: rtl/pscfg_timer.sv
module pscfg_timer #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr_i,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   output logic         expired_o
);

   logic [W-1:0] cnt_q;
   logic         active_q;

   assign expired_o = active_q && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         active_q <= 1'b0;
      end else if (load_i) begin
         cnt_q    <= load_val_i;
         active_q <= 1'b1;
      end else if (clr_i) begin
         cnt_q    <= '0;
         active_q <= 1'b0;
      end else if (active_q) begin
         if (cnt_q == '0) active_q <= 1'b0;
         else             cnt_q    <= cnt_q - 1'b1;
      end
   end

endmodule

// File: rtl/pscfg_shifter.sv
module pscfg_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear_i,
   input  logic         load_i,
   input  logic [W-1:0] data_i,
   input  logic         adv_i,
   output logic         bit_o,
   output logic         need_o
);

   localparam int LW = $clog2(W);

   if (W < 2) begin : g_bad_width
      $error("pscfg_shifter: W must be at least 2");
   end

   logic [W-1:0]  sh_q;
   logic [LW-1:0] left_q;

   assign bit_o  = sh_q[0];
   assign need_o = (left_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         left_q <= '0;
      end else if (clear_i) begin
         sh_q   <= '0;
         left_q <= '0;
      end else if (load_i) begin
         sh_q   <= data_i;
         left_q <= LW'(W - 1);
      end else if (adv_i) begin
         sh_q   <= {1'b0, sh_q[W-1:1]};
         left_q <= left_q - 1'b1;
      end
   end

endmodule

// File: rtl/pscfg_host.sv
module pscfg_host
   import pscfg_pkg::*;
#(
   parameter int CLKS_PER_US = 125,
   parameter int HALF_CYC    = 7,
   parameter int RESET_US    = 2,
   parameter int START_US    = 5,
   parameter int INIT_CLKS   = 10,
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [BYTE_W-1:0] src_data_i,
   input  logic              src_valid_i,
   output logic              src_ready_o,
   output logic              cfg_req_n_o,
   output logic              cfg_clk_o,
   output logic              cfg_data_o,
   input  logic              status_n_i,
   input  logic              done_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              error_o
);

   localparam int RESET_CYC = RESET_US * CLKS_PER_US;
   localparam int START_CYC = START_US * CLKS_PER_US;
   localparam int BIG_CYC   = (RESET_CYC > START_CYC) ? RESET_CYC : START_CYC;
   localparam int MAX_CYC   = (BIG_CYC > HALF_CYC) ? BIG_CYC : HALF_CYC;
   localparam int TMR_W     = $clog2(MAX_CYC + 1);
   localparam int INIT_W    = $clog2(INIT_CLKS + 1);
   localparam int MIN_HALF  = (CLKS_PER_US * 50 + 999) / 1000;

   localparam logic [TMR_W-1:0]  RESET_LD = TMR_W'(RESET_CYC - 1);
   localparam logic [TMR_W-1:0]  START_LD = TMR_W'(START_CYC - 1);
   localparam logic [TMR_W-1:0]  HALF_LD  = TMR_W'(HALF_CYC - 1);
   localparam logic [INIT_W-1:0] INIT_LD  = INIT_W'(INIT_CLKS);

   if (CLKS_PER_US < 1) begin : g_bad_rate
      $error("pscfg_host: CLKS_PER_US must be positive");
   end
   if (HALF_CYC < MIN_HALF || HALF_CYC < 1) begin : g_bad_half
      $error("pscfg_host: HALF_CYC gives a clock phase under 50 ns");
   end
   if (RESET_US < 2) begin : g_bad_reset
      $error("pscfg_host: RESET_US must be at least 2");
   end
   if (START_US < 5) begin : g_bad_start
      $error("pscfg_host: START_US must be at least 5");
   end
   if (INIT_CLKS < 1) begin : g_bad_init
      $error("pscfg_host: INIT_CLKS must be at least 1");
   end

   pscfg_state_e      state_q, state_d;
   logic              cclk_q, cclk_d;
   logic              req_n_q, req_n_d;
   logic              slot_q, slot_d;
   logic [INIT_W-1:0] init_q, init_d;
   logic              tmr_ld, tmr_exp, tmr_clr;
   logic [TMR_W-1:0]  tmr_val;
   logic [1:0]        line_s;
   logic              status_ok, done_seen;
   logic              need, decide, take, start_acc, adv;

   pscfg_sync #(
      .W       (2),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (2'b01)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({done_i, status_n_i}),
      .q_o   (line_s)
   );

   assign status_ok = line_s[0];
   assign done_seen = line_s[1];

   pscfg_timer #(.W(TMR_W)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .clr_i      (tmr_clr),
      .load_i     (tmr_ld),
      .load_val_i (tmr_val),
      .expired_o  (tmr_exp)
   );

   pscfg_shifter #(.W(BYTE_W)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (start_acc),
      .load_i  (take),
      .data_i  (src_data_i),
      .adv_i   (adv),
      .bit_o   (cfg_data_o),
      .need_o  (need)
   );

   assign start_acc   = start_i && (state_q == ST_IDLE || state_q == ST_ERROR);
   assign decide      = (state_q == ST_SHIFT) && slot_q && status_ok && !done_seen;
   assign src_ready_o = decide && need;
   assign take        = src_ready_o && src_valid_i;
   assign adv         = decide && !need;
   assign tmr_clr     = (state_q == ST_IDLE) || (state_q == ST_DONE) || (state_q == ST_ERROR);

   always_comb begin
      state_d = state_q;
      cclk_d  = cclk_q;
      req_n_d = req_n_q;
      slot_d  = slot_q;
      init_d  = init_q;
      tmr_ld  = 1'b0;
      tmr_val = HALF_LD;
      unique case (state_q)
         ST_IDLE, ST_ERROR: begin
            if (start_i) begin
               state_d = ST_RESET_PULSE;
               req_n_d = 1'b0;
               cclk_d  = 1'b0;
               slot_d  = 1'b0;
               tmr_ld  = 1'b1;
               tmr_val = RESET_LD;
            end
         end
         ST_RESET_PULSE: begin
            if (tmr_exp) begin
               state_d = ST_WAIT_START;
               req_n_d = 1'b1;
               tmr_ld  = 1'b1;
               tmr_val = START_LD;
            end
         end
         ST_WAIT_START: begin
            if (tmr_exp) begin
               state_d = ST_SHIFT;
               slot_d  = 1'b1;
            end
         end
         ST_SHIFT: begin
            if (!status_ok) begin
               state_d = ST_ERROR;
               cclk_d  = 1'b0;
               slot_d  = 1'b0;
            end else if (slot_q) begin
               if (done_seen) begin
                  state_d = ST_INIT_CLOCKS;
                  init_d  = INIT_LD;
                  slot_d  = 1'b0;
                  tmr_ld  = 1'b1;
               end else if (need && !src_valid_i) begin
                  state_d = ST_ERROR;
                  slot_d  = 1'b0;
               end else begin
                  slot_d  = 1'b0;
                  tmr_ld  = 1'b1;
               end
            end else if (tmr_exp) begin
               if (!cclk_q) begin
                  cclk_d = 1'b1;
                  tmr_ld = 1'b1;
               end else begin
                  cclk_d = 1'b0;
                  slot_d = 1'b1;
               end
            end
         end
         ST_INIT_CLOCKS: begin
            if (tmr_exp) begin
               if (!cclk_q) begin
                  cclk_d = 1'b1;
                  tmr_ld = 1'b1;
               end else begin
                  cclk_d = 1'b0;
                  if (init_q == INIT_W'(1)) begin
                     state_d = ST_DONE;
                  end else begin
                     init_d = init_q - 1'b1;
                     tmr_ld = 1'b1;
                  end
               end
            end
         end
         ST_DONE: begin
            cclk_d = 1'b0;
         end
         default: begin
            state_d = ST_IDLE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cclk_q  <= 1'b0;
         req_n_q <= 1'b1;
         slot_q  <= 1'b0;
         init_q  <= '0;
      end else begin
         state_q <= state_d;
         cclk_q  <= cclk_d;
         req_n_q <= req_n_d;
         slot_q  <= slot_d;
         init_q  <= init_d;
      end
   end

   assign cfg_clk_o   = cclk_q;
   assign cfg_req_n_o = req_n_q;
   assign busy_o      = (state_q == ST_RESET_PULSE) || (state_q == ST_WAIT_START) ||
                        (state_q == ST_SHIFT) || (state_q == ST_INIT_CLOCKS);
   assign done_o      = (state_q == ST_DONE);
   assign error_o     = (state_q == ST_ERROR);

endmodule

// File: rtl/pscfg_host_chk.sv
module pscfg_host_chk #(
   parameter int CLKS_PER_US = 125,
   parameter int HALF_CYC    = 7,
   parameter int RESET_US    = 2,
   parameter int START_US    = 5
) (
   input logic clk,
   input logic rst_n,
   input logic cfg_req_n_o,
   input logic cfg_clk_o,
   input logic cfg_data_o,
   input logic src_ready_o,
   input logic busy_o,
   input logic done_o,
   input logic error_o
);

   localparam int RESET_CYC = RESET_US * CLKS_PER_US;
   localparam int START_CYC = START_US * CLKS_PER_US;

   logic [31:0] low_len_q, since_rel_q, hi_len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         low_len_q   <= '0;
         since_rel_q <= '0;
         hi_len_q    <= '0;
      end else begin
         if (!cfg_req_n_o) low_len_q <= (low_len_q < 32'(RESET_CYC)) ? low_len_q + 1 : low_len_q;
         else              low_len_q <= '0;
         if (!cfg_req_n_o) since_rel_q <= '0;
         else if (since_rel_q < 32'(START_CYC)) since_rel_q <= since_rel_q + 1;
         if (cfg_clk_o) hi_len_q <= (hi_len_q < 32'(HALF_CYC)) ? hi_len_q + 1 : hi_len_q;
         else           hi_len_q <= '0;
      end
   end

   // R2: the request pulse is long enough
   assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_req_n_o) |-> (low_len_q >= 32'(RESET_CYC - 1)));

   // R3: start-up wait before the first edge
   assert_start_wait_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_clk_o) |-> (since_rel_q >= 32'(START_CYC)));

   // R4: data is stable across a rising edge
   assert_data_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_clk_o) |-> $stable(cfg_data_o));

   // R4: high phase lasts the configured half period
   assert_high_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cfg_clk_o) && !error_o) |-> (hi_len_q >= 32'(HALF_CYC - 1)));

   // R5: bytes are requested only while loading, clock low
   assert_ready_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
      src_ready_o |-> (busy_o && cfg_req_n_o && !cfg_clk_o));

   // R6: done and error never together
   assert_done_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_o && error_o));

   // R7: clock parked low in the error state
   assert_err_clk_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      error_o |-> !cfg_clk_o);

endmodule

bind pscfg_host pscfg_host_chk #(
   .CLKS_PER_US (CLKS_PER_US),
   .HALF_CYC    (HALF_CYC),
   .RESET_US    (RESET_US),
   .START_US    (START_US)
) u_chk (.*);

// File: tb/pscfg_host_test.sv
module pscfg_host_test;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int CPU       = 125;
   localparam int HALF      = 7;
   localparam int INIT      = 10;
   localparam int RESET_CYC = 2 * CPU;
   localparam int START_CYC = 5 * CPU;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       start_i;
   logic [7:0] src_data_i;
   logic       src_valid_i;
   logic       src_ready_o;
   logic       cfg_req_n_o, cfg_clk_o, cfg_data_o;
   logic       status_n_i, done_i;
   logic       busy_o, done_o, error_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #4 clk = ~clk;
   always @(negedge clk) cyc++;

   pscfg_host #(.CLKS_PER_US(CPU), .HALF_CYC(HALF), .INIT_CLKS(INIT)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i),
      .src_data_i(src_data_i), .src_valid_i(src_valid_i), .src_ready_o(src_ready_o),
      .cfg_req_n_o(cfg_req_n_o), .cfg_clk_o(cfg_clk_o), .cfg_data_o(cfg_data_o),
      .status_n_i(status_n_i), .done_i(done_i),
      .busy_o(busy_o), .done_o(done_o), .error_o(error_o)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // byte source and expected-item scoreboard queues
   logic [7:0] src_q[$];
   logic [7:0] exp_q[$];
   bit         take_pend = 1'b0;

   task automatic add_byte(input logic [7:0] b);
      src_q.push_back(b);
      exp_q.push_back(b);
   endtask

   always @(negedge clk) begin
      if (take_pend && src_q.size() > 0) void'(src_q.pop_front());
      src_valid_i = (src_q.size() > 0);
      src_data_i  = src_valid_i ? src_q[0] : 8'h00;
      take_pend   = src_valid_i && src_ready_o && rst_n;
   end

   // target device model and monitor
   int         tgt_bits = 24;
   int         bit_cnt = 0, init_edges = 0, edges_total = 0, req_falls = 0;
   int         acc_n = 0, fall_cyc = 0, rise_cyc = 0, last_rise = 0, last_change = 0;
   bit         first_pend = 1'b0, saw_fall = 1'b0;
   logic [7:0] acc = 8'h00;

   always @(negedge cfg_req_n_o) begin
      bit_cnt    = 0;
      init_edges = 0;
      acc_n      = 0;
      done_i     = 1'b0;
      fall_cyc   = cyc;
      req_falls++;
      saw_fall   = 1'b1;
   end

   always @(posedge cfg_req_n_o) begin
      if (saw_fall) begin
         rise_cyc   = cyc;
         first_pend = 1'b1;
         check(rise_cyc - fall_cyc == RESET_CYC, "R2", "request low cycles",
               rise_cyc - fall_cyc, RESET_CYC);
      end
   end

   always @(cfg_data_o) last_change = cyc;

   always @(posedge cfg_clk_o) begin
      if (cfg_req_n_o) begin
         edges_total++;
         if (first_pend) begin
            check(cyc - rise_cyc >= START_CYC, "R3", "cycles release to first edge",
                  cyc - rise_cyc, START_CYC);
            first_pend = 1'b0;
         end else if (!done_i) begin
            check(cyc - last_rise == 2 * HALF + 1, "R4", "bit period",
                  cyc - last_rise, 2 * HALF + 1);
         end
         last_rise = cyc;
         if (!done_i) begin
            check(cyc - last_change >= HALF, "R4", "data setup cycles",
                  cyc - last_change, HALF);
            acc = {cfg_data_o, acc[7:1]};
            acc_n++;
            bit_cnt++;
            if (acc_n == 8) begin
               acc_n = 0;
               if (exp_q.size() == 0) begin
                  check(1'b0, "R5", "byte sent with none expected", acc, -1);
               end else begin
                  logic [7:0] e;
                  e = exp_q.pop_front();
                  check(acc == e, "R4", "byte received LSB first", acc, e);
               end
            end
            if (bit_cnt == tgt_bits) done_i = 1'b1;
         end else begin
            init_edges++;
         end
      end
   end

   task automatic pulse_start();
      @(negedge clk) start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      src_q.delete();
      exp_q.delete();
      done_i     = 1'b0;
      status_n_i = 1'b1;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   task automatic wait_end(input int max);
      int k = 0;
      while (!(done_o || error_o) && k < max) begin
         @(negedge clk);
         k++;
      end
   endtask

   task automatic wait_bits(input int n, input string req);
      int k = 0;
      while (bit_cnt < n && k < 5000) begin
         @(negedge clk);
         k++;
      end
      check(bit_cnt >= n, req, "bits reached", bit_cnt, n);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "WD", "watchdog expired", cyc, 0);
      finish_run();
   end

   initial begin
      int e0, f0;
      rst_n = 1'b0; start_i = 1'b0; status_n_i = 1'b1; done_i = 1'b0;
      src_valid_i = 1'b0; src_data_i = 8'h00;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1: reset state
      check(cfg_req_n_o == 1'b1 && cfg_clk_o == 1'b0, "R1", "request high clock low",
            {cfg_req_n_o, cfg_clk_o}, 2);
      check(!src_ready_o && !busy_o && !done_o && !error_o, "R1", "flags clear",
            {src_ready_o, busy_o, done_o, error_o}, 0);

      // Full image of three bytes: R2..R6
      tgt_bits = 24;
      add_byte(8'hA5); add_byte(8'h3C); add_byte(8'h81);
      pulse_start();
      wait_end(5000);
      check(done_o && !error_o, "R6", "done after full image", {done_o, error_o}, 2);
      check(init_edges == INIT, "R6", "initialization edges", init_edges, INIT);
      check(bit_cnt == 24, "R4", "bits delivered", bit_cnt, 24);
      check(exp_q.size() == 0 && src_q.size() == 0, "R5", "all bytes taken once",
            exp_q.size() + src_q.size(), 0);

      // R10: start ignored once done
      e0 = edges_total; f0 = req_falls;
      pulse_start();
      repeat (100) @(negedge clk);
      check(req_falls == f0, "R10", "no request pulse after done", req_falls, f0);
      check(edges_total == e0, "R6", "no edges after done", edges_total, e0);
      check(done_o == 1'b1, "R10", "done held", done_o, 1);

      // R8: source starves after two bytes
      do_reset();
      tgt_bits = 24;
      add_byte(8'h00); add_byte(8'hFF);
      pulse_start();
      wait_end(5000);
      check(error_o && !done_o, "R8", "error on empty source", {error_o, done_o}, 2);
      check(bit_cnt == 16, "R8", "bits before starving", bit_cnt, 16);
      e0 = edges_total;
      repeat (100) @(negedge clk);
      check(edges_total == e0 && !cfg_clk_o, "R8", "clock stopped", edges_total, e0);

      // R9: retry from error, with a start during the load ignored (R10)
      add_byte(8'h01); add_byte(8'h80); add_byte(8'h5A);
      f0 = req_falls;
      pulse_start();
      check(cfg_req_n_o == 1'b0 && req_falls == f0 + 1, "R9", "request pulse on retry",
            req_falls, f0 + 1);
      wait_bits(4, "R10");
      f0 = req_falls;
      pulse_start();
      repeat (50) @(negedge clk);
      check(req_falls == f0 && cfg_req_n_o, "R10", "start ignored while busy", req_falls, f0);
      wait_end(5000);
      check(done_o && !error_o, "R9", "retry completes", {done_o, error_o}, 2);
      check(init_edges == INIT, "R6", "initialization edges after retry", init_edges, INIT);

      // R7: status fault mid-load
      do_reset();
      tgt_bits = 24;
      add_byte(8'hC3); add_byte(8'h96); add_byte(8'h7E);
      pulse_start();
      wait_bits(9, "R7");
      status_n_i = 1'b0;
      repeat (30) @(negedge clk);
      check(error_o && !done_o, "R7", "error on status fault", {error_o, done_o}, 2);
      check(!src_ready_o, "R7", "no byte requested in error", src_ready_o, 0);
      e0 = edges_total;
      repeat (100) @(negedge clk);
      check(edges_total == e0 && !cfg_clk_o, "R7", "clock stopped", edges_total, e0);
      status_n_i = 1'b1;

      finish_run();
   end

endmodule